// File: doc/BRIEF.md
# Reset Cause Tracker and Restart Address Selector

This block holds the flags that record why the core last restarted, and it picks the address where execution resumes after a reset or a wake-up. Seven event strobes arrive from the reset and sleep controllers: power-on, brown-out, watchdog reset, watchdog wake-up, pin reset while running, pin reset while asleep, and interrupt wake-up. Each event applies its own mix of set, clear and keep to a time-out flag, a power-down flag, a power-on flag, a brown-out flag and a small bank-select field.

While a strobe is high, the selected restart address appears combinationally on `pc_next`, and `pc_load` is high. The flag registers take their new values on the following clock edge. True resets restart at address zero. Wake-ups resume at the address after the current one, or at the interrupt vector when an interrupt wake-up occurs with global interrupts enabled.

A small write port lets software set the power-on and brown-out flags back to 1 and load the bank field, so that the next restart cause can be told apart. A decoded cause code summarises the flags for software.

Top module: `rstc_top`

## Requirements
- R1: When several strobes are high in one cycle, only the highest-priority strobe takes effect. The order, from highest, is: power-on, brown-out, pin reset while running, pin reset while asleep, watchdog reset, watchdog wake-up, interrupt wake-up.
- R2: A power-on event, and the synchronous `rst` input, make the flags as follows: time-out=1, power-down=1, power-on flag=0, brown-out flag=0, bank=0.
- R3: A brown-out event clears the brown-out flag, sets time-out and power-down to 1, and keeps the power-on flag.
- R4: A watchdog reset gives time-out=0 and power-down=1. A watchdog wake-up gives time-out=0 and power-down=0.
- R5: A pin reset while running keeps time-out and power-down. A pin reset while asleep, and an interrupt wake-up, give time-out=1 and power-down=0.
- R6: Every reset event (power-on, brown-out, both pin resets, watchdog reset) clears the bank field. Both wake-ups keep it.
- R7: Each reset event drives `pc_load`=1 and `pc_next`=0 in the cycle its strobe is high.
- R8: A watchdog wake-up, and an interrupt wake-up with `gie`=0, drive `pc_next`=`pc_cur`+1, wrapping to 0 at the top of the address width.
- R9: An interrupt wake-up with `gie`=1 drives `pc_next`=0x004, the vector address.
- R10: In a cycle with no strobe, `sw_we`=1 sets the power-on flag when `sw_set_pof`=1 and sets the brown-out flag when `sw_set_bof`=1. A 0 on either bit leaves that flag as it was. The same write loads the bank field from `sw_bank`. In a cycle with a strobe, the write is ignored.
- R11: `cause` encodes the registered flags as follows:
  - 1 (power-on) when the power-on flag is 0, including when both the power-on and brown-out flags are 0.
  - Otherwise 2 (brown-out) when the brown-out flag is 0.
  - Otherwise, from time-out and power-down: 3 for 0/1, 4 for 0/0, 5 for 1/0, and 0 for 1/1.
- R12: With no strobe high, `pc_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect on the flags as power-on |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_pin_run | input | 1 | Pin reset while running |
| ev_pin_slp | input | 1 | Pin reset while asleep |
| ev_wdt_rst | input | 1 | Watchdog reset |
| ev_wdt_wake | input | 1 | Watchdog wake-up from sleep |
| ev_irq_wake | input | 1 | Interrupt wake-up from sleep |
| gie | input | 1 | Global interrupt enable |
| pc_cur | input | PC_W | Current program counter |
| sw_we | input | 1 | Software write strobe |
| sw_set_pof | input | 1 | Set power-on flag on write |
| sw_set_bof | input | 1 | Set brown-out flag on write |
| sw_bank | input | BANK_W | Bank value written by software |
| pc_load | output | 1 | Restart address valid this cycle |
| pc_next | output | PC_W | Restart address |
| flag_to | output | 1 | Time-out flag |
| flag_pd | output | 1 | Power-down flag |
| flag_pof | output | 1 | Power-on flag (0 after power-on) |
| flag_bof | output | 1 | Brown-out flag (0 after brown-out) |
| bank_sel | output | BANK_W | Bank-select bits |
| cause | output | 3 | Decoded restart cause |

## Verification
A wrong priority decision or a wrong entry in the flag-update table shows up on the flag ports and on `cause` exactly one clock after the strobe. A wrong address choice shows up on `pc_next` in the same cycle as the strobe. Because `pc_next` is combinational, address faults are caught with no delay. Flag faults, by contrast, can stay hidden until an event whose expected value differs from the stale one. For that reason, the software port preloads the flags and the bank field to values opposite to each event's outcome before the event fires.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef struct packed {
        logic por;
        logic bor;
        logic pin_run;
        logic pin_slp;
        logic wdt_rst;
        logic wdt_wake;
        logic irq_wake;
    } strobes_t;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_POR      = 3'd1,
        EV_BOR      = 3'd2,
        EV_PIN_RUN  = 3'd3,
        EV_PIN_SLP  = 3'd4,
        EV_WDT_RST  = 3'd5,
        EV_WDT_WAKE = 3'd6,
        EV_IRQ_WAKE = 3'd7
    } ev_kind_t;

    typedef struct packed {
        logic to;
        logic pd;
        logic pof;
        logic bof;
    } rflags_t;

    typedef enum logic [2:0] {
        CS_RUN        = 3'd0,
        CS_POWERON    = 3'd1,
        CS_BROWNOUT   = 3'd2,
        CS_WDT_RST    = 3'd3,
        CS_WDT_WAKE   = 3'd4,
        CS_SLEEP_EXIT = 3'd5
    } cause_t;

    localparam rflags_t FLAGS_AFTER_POR = '{to: 1'b1, pd: 1'b1, pof: 1'b0, bof: 1'b0};

    function automatic logic ev_is_reset(ev_kind_t k);
        return (k == EV_POR) || (k == EV_BOR) || (k == EV_PIN_RUN) ||
               (k == EV_PIN_SLP) || (k == EV_WDT_RST);
    endfunction

    function automatic rflags_t next_flags(ev_kind_t k, rflags_t f);
        rflags_t n;
        n = f;
        case (k)
            EV_POR:      n = FLAGS_AFTER_POR;
            EV_BOR:      begin n.to = 1'b1; n.pd = 1'b1; n.bof = 1'b0; end
            EV_PIN_SLP:  begin n.to = 1'b1; n.pd = 1'b0; end
            EV_IRQ_WAKE: begin n.to = 1'b1; n.pd = 1'b0; end
            EV_WDT_RST:  begin n.to = 1'b0; n.pd = 1'b1; end
            EV_WDT_WAKE: begin n.to = 1'b0; n.pd = 1'b0; end
            default:     n = f;
        endcase
        return n;
    endfunction

    function automatic cause_t decode_cause(rflags_t f);
        if (!f.pof)                 return CS_POWERON;
        else if (!f.bof)            return CS_BROWNOUT;
        else if (!f.to &&  f.pd)    return CS_WDT_RST;
        else if (!f.to && !f.pd)    return CS_WDT_WAKE;
        else if ( f.to && !f.pd)    return CS_SLEEP_EXIT;
        else                        return CS_RUN;
    endfunction

endpackage

// File: rtl/rstc_prio.sv
module rstc_prio
    import rstc_pkg::*;
(
    input  strobes_t strobes,
    output ev_kind_t kind
);
    always_comb begin
        if (strobes.por)           kind = EV_POR;
        else if (strobes.bor)      kind = EV_BOR;
        else if (strobes.pin_run)  kind = EV_PIN_RUN;
        else if (strobes.pin_slp)  kind = EV_PIN_SLP;
        else if (strobes.wdt_rst)  kind = EV_WDT_RST;
        else if (strobes.wdt_wake) kind = EV_WDT_WAKE;
        else if (strobes.irq_wake) kind = EV_IRQ_WAKE;
        else                       kind = EV_NONE;
    end
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
    import rstc_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_kind_t          kind,
    input  logic              sw_we,
    input  logic              sw_set_pof,
    input  logic              sw_set_bof,
    input  logic [BANK_W-1:0] sw_bank,
    output rflags_t           flags,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_AFTER_POR;
            bank  <= '0;
        end else if (kind != EV_NONE) begin
            flags <= next_flags(kind, flags);
            if (ev_is_reset(kind))
                bank <= '0;
        end else if (sw_we) begin
            flags.pof <= flags.pof | sw_set_pof;
            flags.bof <= flags.bof | sw_set_bof;
            bank      <= sw_bank;
        end
    end

    p_por_flags_r2: assert property (@(posedge clk) disable iff (rst)
        kind == EV_POR |=> flags.to && flags.pd && !flags.pof && !flags.bof);
    p_bor_flags_r3: assert property (@(posedge clk) disable iff (rst)
        kind == EV_BOR |=> flags.to && flags.pd && !flags.bof && $stable(flags.pof));
    p_wdt_rst_r4: assert property (@(posedge clk) disable iff (rst)
        kind == EV_WDT_RST |=> !flags.to && flags.pd);
    p_wdt_wake_r4: assert property (@(posedge clk) disable iff (rst)
        kind == EV_WDT_WAKE |=> !flags.to && !flags.pd);
    p_pin_run_keep_r5: assert property (@(posedge clk) disable iff (rst)
        kind == EV_PIN_RUN |=> $stable(flags.to) && $stable(flags.pd));
    p_sleep_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_PIN_SLP || kind == EV_IRQ_WAKE) |=> flags.to && !flags.pd);
    p_bank_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ev_is_reset(kind) |=> bank == '0);
    p_bank_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_WDT_WAKE || kind == EV_IRQ_WAKE) |=> $stable(bank));
    p_sw_set_r10: assert property (@(posedge clk) disable iff (rst)
        (kind == EV_NONE && sw_we && sw_set_pof) |=> flags.pof);
endmodule

// File: rtl/rstc_pcsel.sv
module rstc_pcsel
    import rstc_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int VEC_ADDR = 4
) (
    input  ev_kind_t        kind,
    input  logic            gie,
    input  logic [PC_W-1:0] pc_cur,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_next
);
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

    logic [PC_W-1:0] pc_inc;
    assign pc_inc = pc_cur + PC_W'(1);

    always_comb begin
        pc_load = (kind != EV_NONE);
        case (kind)
            EV_WDT_WAKE: pc_next = pc_inc;
            EV_IRQ_WAKE: pc_next = gie ? VEC : pc_inc;
            default:     pc_next = '0;
        endcase
    end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int BANK_W   = 3,
    parameter int VEC_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_por,
    input  logic              ev_bor,
    input  logic              ev_pin_run,
    input  logic              ev_pin_slp,
    input  logic              ev_wdt_rst,
    input  logic              ev_wdt_wake,
    input  logic              ev_irq_wake,
    input  logic              gie,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              sw_we,
    input  logic              sw_set_pof,
    input  logic              sw_set_bof,
    input  logic [BANK_W-1:0] sw_bank,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next,
    output logic              flag_to,
    output logic              flag_pd,
    output logic              flag_pof,
    output logic              flag_bof,
    output logic [BANK_W-1:0] bank_sel,
    output logic [2:0]        cause
);
    strobes_t strobes;
    ev_kind_t kind;
    rflags_t  flags;

    assign strobes = '{por: ev_por, bor: ev_bor, pin_run: ev_pin_run,
                       pin_slp: ev_pin_slp, wdt_rst: ev_wdt_rst,
                       wdt_wake: ev_wdt_wake, irq_wake: ev_irq_wake};

    rstc_prio u_prio (.strobes(strobes), .kind(kind));

    rstc_flags #(.BANK_W(BANK_W)) u_flags (
        .clk(clk), .rst(rst), .kind(kind),
        .sw_we(sw_we), .sw_set_pof(sw_set_pof), .sw_set_bof(sw_set_bof),
        .sw_bank(sw_bank), .flags(flags), .bank(bank_sel)
    );

    rstc_pcsel #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_pcsel (
        .kind(kind), .gie(gie), .pc_cur(pc_cur),
        .pc_load(pc_load), .pc_next(pc_next)
    );

    assign flag_to  = flags.to;
    assign flag_pd  = flags.pd;
    assign flag_pof = flags.pof;
    assign flag_bof = flags.bof;
    assign cause    = decode_cause(flags);

    p_por_wins_r1: assert property (@(posedge clk) disable iff (rst)
        ev_por |=> !flag_pof && !flag_bof);
    p_bor_over_wdt_r1: assert property (@(posedge clk) disable iff (rst)
        (ev_bor && !ev_por) |=> flag_to && flag_pd);
    p_reset_pc_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_por || ev_bor || ev_pin_run || ev_pin_slp || ev_wdt_rst) |-> pc_load && pc_next == '0);
    p_irq_vector_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_irq_wake && gie && !(ev_por || ev_bor || ev_pin_run || ev_pin_slp || ev_wdt_rst || ev_wdt_wake))
        |-> pc_next == PC_W'(VEC_ADDR));
    p_idle_no_load_r12: assert property (@(posedge clk) disable iff (rst)
        !(ev_por || ev_bor || ev_pin_run || ev_pin_slp || ev_wdt_rst || ev_wdt_wake || ev_irq_wake) |-> !pc_load);
    p_cause_por_r11: assert property (@(posedge clk) disable iff (rst)
        !flag_pof |-> cause == 3'd1);
endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
    localparam int PC_W = 13;
    localparam int BANK_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_por = 0, ev_bor = 0, ev_pin_run = 0, ev_pin_slp = 0;
    logic ev_wdt_rst = 0, ev_wdt_wake = 0, ev_irq_wake = 0;
    logic gie = 0;
    logic [PC_W-1:0] pc_cur = '0;
    logic sw_we = 0, sw_set_pof = 0, sw_set_bof = 0;
    logic [BANK_W-1:0] sw_bank = '0;
    logic pc_load;
    logic [PC_W-1:0] pc_next;
    logic flag_to, flag_pd, flag_pof, flag_bof;
    logic [BANK_W-1:0] bank_sel;
    logic [2:0] cause;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rstc_top #(.PC_W(PC_W), .BANK_W(BANK_W), .VEC_ADDR(4)) dut (
        .clk(clk), .rst(rst), .ev_por(ev_por), .ev_bor(ev_bor),
        .ev_pin_run(ev_pin_run), .ev_pin_slp(ev_pin_slp), .ev_wdt_rst(ev_wdt_rst),
        .ev_wdt_wake(ev_wdt_wake), .ev_irq_wake(ev_irq_wake), .gie(gie),
        .pc_cur(pc_cur), .sw_we(sw_we), .sw_set_pof(sw_set_pof),
        .sw_set_bof(sw_set_bof), .sw_bank(sw_bank), .pc_load(pc_load),
        .pc_next(pc_next), .flag_to(flag_to), .flag_pd(flag_pd),
        .flag_pof(flag_pof), .flag_bof(flag_bof), .bank_sel(bank_sel), .cause(cause)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(string req, int to, int pd, int pof, int bof, int bank);
        chk(req, "to", int'(flag_to), to);
        chk(req, "pd", int'(flag_pd), pd);
        chk(req, "pof", int'(flag_pof), pof);
        chk(req, "bof", int'(flag_bof), bof);
        chk(req, "bank", int'(bank_sel), bank);
    endtask

    // mask bits: 6 por, 5 bor, 4 pin_run, 3 pin_slp, 2 wdt_rst, 1 wdt_wake, 0 irq_wake
    task automatic fire(string req, logic [6:0] m, int exp_pc);
        @(negedge clk);
        {ev_por, ev_bor, ev_pin_run, ev_pin_slp, ev_wdt_rst, ev_wdt_wake, ev_irq_wake} = m;
        #1;
        chk(req, "pc_load", int'(pc_load), 1);
        chk(req, "pc_next", int'(pc_next), exp_pc);
        @(negedge clk);
        {ev_por, ev_bor, ev_pin_run, ev_pin_slp, ev_wdt_rst, ev_wdt_wake, ev_irq_wake} = '0;
    endtask

    task automatic sw_write(logic pof, logic bof, logic [BANK_W-1:0] b);
        @(negedge clk);
        sw_we = 1; sw_set_pof = pof; sw_set_bof = bof; sw_bank = b;
        @(negedge clk);
        sw_we = 0; sw_set_pof = 0; sw_set_bof = 0;
    endtask

    task automatic t_reset();
        chk_flags("R2", 1, 1, 0, 0, 0);
        chk("R11", "cause both-zero", int'(cause), 1);
        chk("R12", "pc_load idle", int'(pc_load), 0);
    endtask

    task automatic t_sw();
        sw_write(1, 1, 3'd5);
        chk_flags("R10", 1, 1, 1, 1, 5);
        chk("R11", "cause run", int'(cause), 0);
        sw_write(0, 0, 3'd5);
        chk_flags("R10", 1, 1, 1, 1, 5);
    endtask

    task automatic t_bor();
        fire("R7", 7'b0100000, 0);
        chk_flags("R3", 1, 1, 1, 0, 0);
        chk("R11", "cause brownout", int'(cause), 2);
    endtask

    task automatic t_wdt();
        sw_write(1, 1, 3'd3);
        fire("R7", 7'b0000100, 0);
        chk_flags("R4", 0, 1, 1, 1, 0);
        chk("R11", "cause wdt rst", int'(cause), 3);
        sw_write(0, 0, 3'd6);
        pc_cur = 13'h123;
        fire("R8", 7'b0000010, 'h124);
        chk_flags("R4", 0, 0, 1, 1, 6);
        chk("R6", "bank kept wdt wake", int'(bank_sel), 6);
        chk("R11", "cause wdt wake", int'(cause), 4);
    endtask

    task automatic t_pin();
        fire("R7", 7'b0001000, 0);
        chk_flags("R5", 1, 0, 1, 1, 0);
        chk("R11", "cause sleep exit", int'(cause), 5);
        sw_write(0, 0, 3'd2);
        fire("R7", 7'b0010000, 0);
        chk_flags("R5", 1, 0, 1, 1, 0);
        chk("R6", "bank cleared pin", int'(bank_sel), 0);
        fire("R7", 7'b0000100, 0);
        fire("R5", 7'b0010000, 0);
        chk_flags("R5", 0, 1, 1, 1, 0);
    endtask

    task automatic t_irq();
        sw_write(0, 0, 3'd7);
        gie = 0; pc_cur = 13'h1FFF;
        fire("R8", 7'b0000001, 0);
        chk_flags("R5", 1, 0, 1, 1, 7);
        chk("R6", "bank kept irq", int'(bank_sel), 7);
        gie = 1; pc_cur = 13'h050;
        fire("R9", 7'b0000001, 4);
        chk_flags("R9", 1, 0, 1, 1, 7);
        gie = 0;
    endtask

    task automatic t_prio();
        sw_write(1, 1, 3'd1);
        fire("R1", 7'b1100000, 0);
        chk_flags("R1", 1, 1, 0, 0, 0);
        sw_write(1, 1, 3'd1);
        fire("R1", 7'b0100100, 0);
        chk_flags("R1", 1, 1, 1, 0, 0);
        sw_write(1, 1, 3'd1);
        pc_cur = 13'h010;
        fire("R1", 7'b0010010, 0);
        chk_flags("R1", 1, 1, 1, 1, 0);
        gie = 1;
        fire("R1", 7'b0000101, 0);
        chk_flags("R1", 0, 1, 1, 1, 0);
        gie = 0;
    endtask

    task automatic t_conflict();
        sw_write(1, 1, 3'd4);
        @(negedge clk);
        ev_por = 1; sw_we = 1; sw_set_pof = 1; sw_set_bof = 1; sw_bank = 3'd6;
        @(negedge clk);
        ev_por = 0; sw_we = 0; sw_set_pof = 0; sw_set_bof = 0;
        chk_flags("R10", 1, 1, 0, 0, 0);
    endtask

    task automatic t_rst_mid();
        sw_write(1, 1, 3'd2);
        fire("R4", 7'b0000010, 'h011);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk_flags("R2", 1, 1, 0, 0, 0);
        chk("R12", "pc_load idle", int'(pc_load), 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_sw();
        t_bor();
        t_wdt();
        t_pin();
        t_irq();
        t_prio();
        t_conflict();
        t_rst_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule